// File: doc/BRIEF.md
# Voice Recorder Command Sequencer

This block is the controller-side driver for a serial voice record/playback chip. A user asks for one of four operations (record from a given row, record from where the chip last stopped, play from a given row, play from where it last stopped) or asks to stop a running one. The block then walks the chip through its start-up order. For playback it sends one power-up frame and waits one power-up delay. For record it sends two power-up frames, the first followed by one power-up delay and the second by two. It then sends the frame that starts the operation and holds it running. The operation ends on a stop request or, for playback only, when the chip pulls its interrupt line low. After either ending the block holds the post-stop pause before it accepts new work.

Every command is a 16-bit frame sent least significant bit first, in SPI mode 0. The clock idles low, the data bit changes on the falling edge and is sampled on the rising edge. The minimum select setup, hold and select-high times are counted in system clock cycles. Each frame also shifts in the chip's status word, and the block reports the overflow flag, the end-of-message flag and the 10-bit row pointer as soon as the frame is complete. All timing is set by parameters in system clock cycles, so a fast simulation can shorten the delays.

Top module: `voice_cmd_seq`

## Requirements
- R1: Each frame holds select low for exactly 16 rising clock edges and carries, least significant bit first, bits 0-9 = row address, bit 10 = 0 and bits 11-15 = control bits C0..C4. The frame values are: power-up 0x2000, set-record 0xA000|row, record-here 0xB000, set-play 0xE000|row, play-here 0xF000, stop 0x3000.
- R2: The serial clock is low whenever select is high. Each high phase and each low phase inside a frame lasts HALF_CYC cycles. MOSI stays stable while the clock is high.
- R3: Select falls at least SETUP_CYC cycles before the first rising edge. It rises at least HOLD_CYC cycles after the last falling edge. It stays high at least GAP_CYC cycles between frames.
- R4: A record request (req_op 0 = at address, 1 = here) sends two power-up frames and then the set-record or record-here frame. `running` then goes high.
- R5: A play request (req_op 2 = at address, 3 = here) sends one power-up frame and then the set-play or play-here frame. `running` then goes high and no frame is sent while it stays high.
- R6: From select rising at the end of a power-up frame to select falling for the next frame takes PUD_CYC+GAP_CYC to PUD_CYC+GAP_CYC+6 cycles. After the second power-up frame of a record sequence it takes 2·PUD_CYC+GAP_CYC to 2·PUD_CYC+GAP_CYC+6 cycles.
- R7: A stop request (req_op 4) while running sends the stop frame. `busy` then falls STOP_CYC+GAP_CYC to STOP_CYC+GAP_CYC+6 cycles after that frame's select rises.
- R8: During playback, a low level on int_n (passed through a two-stage synchronizer) ends the operation without any frame. `busy` falls STOP_CYC to STOP_CYC+8 cycles after int_n goes low.
- R9: During recording, int_n has no effect: `running` stays high and no frame is sent.
- R10: When a stop request and a synchronized interrupt reach a running playback in the same cycle, the stop request wins and the stop frame is sent.
- R11: A start request while `busy` is high, a stop request while not running, and req_op values 5-7 are all ignored. No frame is sent and the sequence in progress is unchanged.
- R12: After each frame, `stat_valid` pulses for one cycle while select is high. At that pulse `stat_ovf`, `stat_eom` and `stat_row` equal MISO bits 0, 1 and 2-11 as sampled on that frame's rising edges.
- R13: During reset, select is high, the clock is low, MOSI is low, and `busy`, `running` and `stat_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_op | input | 3 | Request code: 0 rec at row, 1 rec here, 2 play at row, 3 play here, 4 stop |
| req_addr | input | 10 | Start row for the at-address requests |
| busy | output | 1 | Sequence in progress, start requests ignored |
| running | output | 1 | Record or playback under way, stop accepted |
| stat_valid | output | 1 | One-cycle pulse when a frame's status word is ready |
| stat_ovf | output | 1 | Overflow flag from the last frame |
| stat_eom | output | 1 | End-of-message flag from the last frame |
| stat_row | output | 10 | Row pointer from the last frame |
| spi_sclk | output | 1 | Serial clock to the chip |
| spi_mosi | output | 1 | Serial data to the chip |
| spi_ss_n | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial status data from the chip |
| int_n | input | 1 | Active-low interrupt from the chip |

## Verification
The stop request and the end-of-playback interrupt can both reach the running state in the same cycle. The bench lowers int_n two negative edges before it strobes the stop request, so the synchronized interrupt and the request reach the sequencer together. The case is judged at the serial pins: a stop frame of 0x3000 must appear, followed by the normal post-stop pause. The alternative outcome would be a silent pause with no frame.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    localparam int ADDR_BITS  = 10;
    localparam int CTRL_BITS  = 5;
    localparam int FRAME_BITS = CTRL_BITS + 1 + ADDR_BITS;
    localparam int STAT_BITS  = 2 + ADDR_BITS;

    // control field, index 0 = C0 (cue), 1 = ignore address, 2 = power,
    // 3 = play not record, 4 = run
    localparam logic [CTRL_BITS-1:0] CTL_PWRUP   = 5'b00100;
    localparam logic [CTRL_BITS-1:0] CTL_SETPLAY = 5'b11100;
    localparam logic [CTRL_BITS-1:0] CTL_PLAY    = 5'b11110;
    localparam logic [CTRL_BITS-1:0] CTL_SETREC  = 5'b10100;
    localparam logic [CTRL_BITS-1:0] CTL_REC     = 5'b10110;
    localparam logic [CTRL_BITS-1:0] CTL_STOP    = 5'b00110;

    typedef enum logic [2:0] {
        OP_REC_AT    = 3'd0,
        OP_REC_HERE  = 3'd1,
        OP_PLAY_AT   = 3'd2,
        OP_PLAY_HERE = 3'd3,
        OP_STOP      = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        F_IDLE, F_SETUP, F_LOW, F_HIGH, F_HOLD, F_GAP
    } fstate_e;

    typedef enum logic [3:0] {
        S_IDLE, S_PU1, S_W1, S_PU2, S_W2, S_GO, S_RUN, S_STOPF, S_PAUSE
    } sstate_e;

    function automatic logic [FRAME_BITS-1:0] make_frame(
        input logic [CTRL_BITS-1:0] ctl,
        input logic [ADDR_BITS-1:0] row
    );
        return {ctl, 1'b0, row};
    endfunction

endpackage

// File: rtl/vseq_sync.sv
module vseq_sync #(
    parameter int   STAGES   = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/vseq_timer.sv
module vseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] len,
    output logic         done
);
    typedef struct packed {
        logic         run;
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (start) begin
            d.run = 1'b1;
            d.cnt = len - W'(1);
        end else if (q.run) begin
            if (q.cnt == '0) d.run = 1'b0;
            else             d.cnt = q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.run && (q.cnt == '0);
endmodule

// File: rtl/vseq_spi_frame.sv
module vseq_spi_frame
    import vseq_pkg::*;
#(
    parameter int BITS      = 16,
    parameter int CAP_BITS  = 12,
    parameter int HALF_CYC  = 25,
    parameter int SETUP_CYC = 25,
    parameter int HOLD_CYC  = 25,
    parameter int GAP_CYC   = 50
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [BITS-1:0]     tx,
    input  logic                miso,
    output logic                sclk,
    output logic                ss_n,
    output logic                mosi,
    output logic                done,
    output logic [CAP_BITS-1:0] rx
);
    localparam int M1   = (HALF_CYC > SETUP_CYC) ? HALF_CYC : SETUP_CYC;
    localparam int M2   = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
    localparam int MAXC = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int BW   = $clog2(BITS);

    typedef struct packed {
        fstate_e             st;
        logic [CW-1:0]       cnt;
        logic [BW-1:0]       bitn;
        logic [BITS-1:0]     sh;
        logic [CAP_BITS-1:0] cap;
        logic [CAP_BITS-1:0] rx;
        logic                done;
    } fr_t;

    fr_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            F_IDLE: begin
                if (start) begin
                    d.sh   = tx;
                    d.bitn = '0;
                    d.cnt  = CW'(SETUP_CYC - 1);
                    d.st   = F_SETUP;
                end
            end
            F_SETUP: begin
                if (q.cnt == '0) begin
                    d.cnt = CW'(HALF_CYC - 1);
                    d.st  = F_LOW;
                end else d.cnt = q.cnt - CW'(1);
            end
            F_LOW: begin
                if (q.cnt == '0) begin
                    d.cnt = CW'(HALF_CYC - 1);
                    d.st  = F_HIGH;
                    if (q.bitn < BW'(CAP_BITS))
                        d.cap = {miso, q.cap[CAP_BITS-1:1]};
                end else d.cnt = q.cnt - CW'(1);
            end
            F_HIGH: begin
                if (q.cnt == '0) begin
                    if (q.bitn == BW'(BITS - 1)) begin
                        d.cnt = CW'(HOLD_CYC - 1);
                        d.st  = F_HOLD;
                    end else begin
                        d.bitn = q.bitn + BW'(1);
                        d.sh   = q.sh >> 1;
                        d.cnt  = CW'(HALF_CYC - 1);
                        d.st   = F_LOW;
                    end
                end else d.cnt = q.cnt - CW'(1);
            end
            F_HOLD: begin
                if (q.cnt == '0) begin
                    d.cnt = CW'(GAP_CYC - 1);
                    d.st  = F_GAP;
                end else d.cnt = q.cnt - CW'(1);
            end
            F_GAP: begin
                if (q.cnt == '0) begin
                    d.rx   = q.cap;
                    d.done = 1'b1;
                    d.st   = F_IDLE;
                end else d.cnt = q.cnt - CW'(1);
            end
            default: d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: F_IDLE, default: '0};
        else        q <= d;
    end

    assign sclk = (q.st == F_HIGH);
    assign ss_n = (q.st == F_IDLE) || (q.st == F_GAP);
    assign mosi = ((q.st == F_SETUP) || (q.st == F_LOW) || (q.st == F_HIGH)) ? q.sh[0] : 1'b0;
    assign done = q.done;
    assign rx   = q.rx;
endmodule

// File: rtl/voice_cmd_seq.sv
module voice_cmd_seq
    import vseq_pkg::*;
#(
    parameter int HALF_CYC    = 25,
    parameter int SETUP_CYC   = 25,
    parameter int HOLD_CYC    = 25,
    parameter int GAP_CYC     = 50,
    parameter int PUD_CYC     = 1250000,
    parameter int STOP_CYC    = 2500000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [2:0]           req_op,
    input  logic [ADDR_BITS-1:0] req_addr,
    output logic                 busy,
    output logic                 running,
    output logic                 stat_valid,
    output logic                 stat_ovf,
    output logic                 stat_eom,
    output logic [ADDR_BITS-1:0] stat_row,
    output logic                 spi_sclk,
    output logic                 spi_mosi,
    output logic                 spi_ss_n,
    input  logic                 spi_miso,
    input  logic                 int_n
);
    localparam int LONGEST = (2 * PUD_CYC > STOP_CYC) ? 2 * PUD_CYC : STOP_CYC;
    localparam int TW      = $clog2(LONGEST + 1);

    typedef struct packed {
        sstate_e              st;
        logic                 is_rec;
        logic                 use_addr;
        logic [ADDR_BITS-1:0] addr;
    } seq_t;

    seq_t d, q;

    logic                  f_start, f_done, t_start, t_done, int_s;
    logic [FRAME_BITS-1:0] f_tx, go_frame;
    logic [TW-1:0]         t_len;
    logic [STAT_BITS-1:0]  f_rx;

    vseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(int_n), .dout(int_s)
    );

    vseq_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(t_start), .len(t_len), .done(t_done)
    );

    vseq_spi_frame #(
        .BITS(FRAME_BITS), .CAP_BITS(STAT_BITS), .HALF_CYC(HALF_CYC),
        .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .GAP_CYC(GAP_CYC)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .start(f_start), .tx(f_tx), .miso(spi_miso),
        .sclk(spi_sclk), .ss_n(spi_ss_n), .mosi(spi_mosi), .done(f_done), .rx(f_rx)
    );

    always_comb begin
        logic [CTRL_BITS-1:0] ctl;
        if (q.is_rec) ctl = q.use_addr ? CTL_SETREC : CTL_REC;
        else          ctl = q.use_addr ? CTL_SETPLAY : CTL_PLAY;
        go_frame = make_frame(ctl, q.use_addr ? q.addr : '0);
    end

    always_comb begin
        d       = q;
        f_start = 1'b0;
        f_tx    = '0;
        t_start = 1'b0;
        t_len   = '0;
        case (q.st)
            S_IDLE: begin
                // codes 0..3 start an operation; bit1 low = record, bit0 low = at address
                if (req_valid && !req_op[2]) begin
                    d.is_rec   = !req_op[1];
                    d.use_addr = !req_op[0];
                    d.addr     = req_addr;
                    f_start    = 1'b1;
                    f_tx       = make_frame(CTL_PWRUP, '0);
                    d.st       = S_PU1;
                end
            end
            S_PU1: begin
                if (f_done) begin
                    t_start = 1'b1;
                    t_len   = TW'(PUD_CYC);
                    d.st    = S_W1;
                end
            end
            S_W1: begin
                if (t_done) begin
                    f_start = 1'b1;
                    if (q.is_rec) begin
                        f_tx = make_frame(CTL_PWRUP, '0);
                        d.st = S_PU2;
                    end else begin
                        f_tx = go_frame;
                        d.st = S_GO;
                    end
                end
            end
            S_PU2: begin
                if (f_done) begin
                    t_start = 1'b1;
                    t_len   = TW'(2 * PUD_CYC);
                    d.st    = S_W2;
                end
            end
            S_W2: begin
                if (t_done) begin
                    f_start = 1'b1;
                    f_tx    = go_frame;
                    d.st    = S_GO;
                end
            end
            S_GO: begin
                if (f_done) d.st = S_RUN;
            end
            S_RUN: begin
                if (req_valid && (req_op == OP_STOP)) begin
                    f_start = 1'b1;
                    f_tx    = make_frame(CTL_STOP, '0);
                    d.st    = S_STOPF;
                end else if (!q.is_rec && !int_s) begin
                    t_start = 1'b1;
                    t_len   = TW'(STOP_CYC);
                    d.st    = S_PAUSE;
                end
            end
            S_STOPF: begin
                if (f_done) begin
                    t_start = 1'b1;
                    t_len   = TW'(STOP_CYC);
                    d.st    = S_PAUSE;
                end
            end
            S_PAUSE: begin
                if (t_done) d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= d;
    end

    assign busy       = (q.st != S_IDLE);
    assign running    = (q.st == S_RUN);
    assign stat_valid = f_done;
    assign stat_ovf   = f_rx[0];
    assign stat_eom   = f_rx[1];
    assign stat_row   = f_rx[STAT_BITS-1:2];
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic running,
    input logic stat_valid,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_ss_n
);
    // R2: clock quiet outside a frame
    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_ss_n |-> !spi_sclk);

    // R2: data held while the clock is high
    p_mosi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R5: nothing on the wire while an operation runs
    p_run_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (busy && spi_ss_n));

    // R11: no frame while idle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_ss_n);

    // R12: status pulse lasts one cycle and follows a closed frame
    p_stat_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid);

    p_stat_sel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> spi_ss_n);
endmodule

bind voice_cmd_seq vseq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .running(running),
    .stat_valid(stat_valid), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_ss_n(spi_ss_n)
);

// File: tb/tb_voice_cmd_seq.sv
module tb_voice_cmd_seq;
    localparam int H   = 2;
    localparam int SU  = 3;
    localparam int HO  = 3;
    localparam int GP  = 5;
    localparam int PUD = 40;
    localparam int STP = 60;
    localparam logic [15:0] F_PU   = 16'h2000;
    localparam logic [15:0] F_STOP = 16'h3000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, req_valid, int_n, spi_miso;
    logic [2:0] req_op;
    logic [9:0] req_addr, stat_row;
    logic       busy, running, stat_valid, stat_ovf, stat_eom;
    logic       spi_sclk, spi_mosi, spi_ss_n;

    voice_cmd_seq #(
        .HALF_CYC(H), .SETUP_CYC(SU), .HOLD_CYC(HO), .GAP_CYC(GP),
        .PUD_CYC(PUD), .STOP_CYC(STP), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .busy(busy), .running(running),
        .stat_valid(stat_valid), .stat_ovf(stat_ovf), .stat_eom(stat_eom),
        .stat_row(stat_row), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_ss_n(spi_ss_n), .spi_miso(spi_miso), .int_n(int_n)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_tb();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    // bus monitor and chip model
    int          cyc = 0;
    logic [15:0] fr   [0:511];
    int          fs_t [0:511];
    int          fe_t [0:511];
    int          fr_cnt = 0;
    int          busy_fall_t = 0;
    logic [15:0] slave_w, last_w;

    initial begin
        logic        p_sclk, p_ss, p_busy, mosi_rise, mosi_bad;
        int          ss_fall_t, ss_rise_t, edge_t, bitn, sidx;
        logic [15:0] cur;
        p_sclk = 1'b0; p_ss = 1'b1; p_busy = 1'b0; mosi_rise = 1'b0; mosi_bad = 1'b0;
        ss_fall_t = 0; ss_rise_t = -1000; edge_t = 0; bitn = 0; sidx = 0; cur = '0;
        spi_miso = 1'b0; slave_w = '0; last_w = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (p_ss && !spi_ss_n) begin
                    chk(cyc - ss_rise_t >= GP, "R3 select high gap", cyc - ss_rise_t, GP);
                    ss_fall_t = cyc; bitn = 0; cur = '0;
                    slave_w = 16'($urandom);
                    spi_miso = slave_w[0]; sidx = 1;
                end
                if (spi_sclk && p_sclk && (spi_mosi != mosi_rise)) mosi_bad = 1'b1;
                if (!p_sclk && spi_sclk) begin
                    chk(!spi_ss_n, "R2 clock while deselected", 1, 0);
                    if (bitn == 0) chk(cyc - ss_fall_t >= SU, "R3 select setup", cyc - ss_fall_t, SU);
                    else           chk(cyc - edge_t == H, "R2 low phase", cyc - edge_t, H);
                    if (bitn < 16) cur[bitn] = spi_mosi;
                    bitn++; edge_t = cyc; mosi_rise = spi_mosi; mosi_bad = 1'b0;
                end
                if (p_sclk && !spi_sclk) begin
                    chk(cyc - edge_t == H, "R2 high phase", cyc - edge_t, H);
                    chk(!mosi_bad, "R2 mosi moved while clock high", 1, 0);
                    edge_t = cyc;
                    if (sidx < 16) begin spi_miso = slave_w[sidx]; sidx++; end
                end
                if (!p_ss && spi_ss_n) begin
                    chk(bitn == 16, "R1 rising edges per frame", bitn, 16);
                    chk(cyc - edge_t >= HO, "R3 select hold", cyc - edge_t, HO);
                    if (fr_cnt < 512) begin
                        fr[fr_cnt] = cur; fs_t[fr_cnt] = ss_fall_t; fe_t[fr_cnt] = cyc;
                        fr_cnt++;
                    end
                    ss_rise_t = cyc; last_w = slave_w;
                end
                if (p_busy && !busy) busy_fall_t = cyc;
                if (stat_valid)
                    chk({stat_row, stat_eom, stat_ovf} == last_w[11:0], "R12 status word",
                        int'({stat_row, stat_eom, stat_ovf}), int'(last_w[11:0]));
            end
            p_sclk = spi_sclk; p_ss = spi_ss_n; p_busy = busy;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_tb();
    end

    function automatic logic [15:0] exp_go(input logic [2:0] op, input logic [9:0] a);
        case (op)
            3'd0:    return {5'b10100, 1'b0, a};
            3'd1:    return 16'hB000;
            3'd2:    return {5'b11100, 1'b0, a};
            default: return 16'hF000;
        endcase
    endfunction

    task automatic send_req(input logic [2:0] op, input logic [9:0] a);
        req_valid = 1'b1; req_op = op; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // end_mode: 0 stop request, 1 interrupt, 2 stop and interrupt together
    task automatic run_op(input logic [2:0] op, input logic [9:0] a,
                          input int end_mode, input int hold, input bit poke);
        int base, nf, g, t0;
        bit rec;
        base = fr_cnt;
        rec  = (op <= 3'd1);
        nf   = rec ? 3 : 2;
        send_req(op, a);
        if (poke) begin
            repeat (10) @(negedge clk);
            send_req(op ^ 3'd1, ~a);   // R11 start while busy
            send_req(3'd4, 10'd0);     // R11 stop while not running
        end
        while (!running) @(negedge clk);
        @(negedge clk);
        chk(fr_cnt - base == nf, rec ? "R4 frames before run" : "R5 frames before run", fr_cnt - base, nf);
        chk(fr[base] == F_PU, rec ? "R4 first power-up" : "R5 power-up", fr[base], F_PU);
        g = fs_t[base+1] - fe_t[base];
        chk(g >= PUD + GP && g <= PUD + GP + 6, "R6 single power-up wait", g, PUD + GP);
        if (rec) begin
            chk(fr[base+1] == F_PU, "R4 second power-up", fr[base+1], F_PU);
            g = fs_t[base+2] - fe_t[base+1];
            chk(g >= 2*PUD + GP && g <= 2*PUD + GP + 6, "R6 double power-up wait", g, 2*PUD + GP);
        end
        chk(fr[base+nf-1] == exp_go(op, a), rec ? "R4 start frame" : "R5 start frame",
            fr[base+nf-1], exp_go(op, a));
        if (rec && poke) begin
            int_n = 1'b0;
            repeat (30) @(negedge clk);
            chk(running && fr_cnt == base + nf, "R9 interrupt ignored in record", fr_cnt - base, nf);
            int_n = 1'b1;
            repeat (4) @(negedge clk);
        end
        repeat (hold) @(negedge clk);
        if (rec || end_mode == 0) begin
            send_req(3'd4, 10'd0);
            while (busy) @(negedge clk);
            repeat (2) @(negedge clk);
            chk(fr_cnt == base + nf + 1, "R7 one stop frame", fr_cnt - base, nf + 1);
            chk(fr[base+nf] == F_STOP, "R7 stop frame value", fr[base+nf], F_STOP);
            g = busy_fall_t - fe_t[base+nf];
            chk(g >= STP + GP && g <= STP + GP + 6, "R7 post-stop pause", g, STP + GP);
        end else if (end_mode == 1) begin
            int_n = 1'b0; t0 = cyc;
            while (busy) @(negedge clk);
            repeat (2) @(negedge clk);
            chk(fr_cnt == base + nf, "R8 no frame on interrupt", fr_cnt - base, nf);
            g = busy_fall_t - t0;
            chk(g >= STP && g <= STP + 8, "R8 pause after interrupt", g, STP);
            int_n = 1'b1;
        end else begin
            int_n = 1'b0;
            @(negedge clk);
            @(negedge clk);
            send_req(3'd4, 10'd0);
            while (busy) @(negedge clk);
            repeat (2) @(negedge clk);
            chk(fr_cnt == base + nf + 1 && fr[base+nf] == F_STOP, "R10 stop wins over interrupt",
                fr[base+nf], F_STOP);
            int_n = 1'b1;
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int base;
        void'($urandom(32'h5EED));
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; int_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(spi_ss_n && !spi_sclk && !spi_mosi, "R13 reset pins", {spi_ss_n, spi_sclk, spi_mosi}, 3'b100);
        chk(!busy && !running && !stat_valid, "R13 reset flags", {busy, running, stat_valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R11: stop and reserved codes in idle
        base = fr_cnt;
        send_req(3'd4, 10'd0);
        send_req(3'd5, 10'h155);
        send_req(3'd7, 10'h2AA);
        repeat (30) @(negedge clk);
        chk(fr_cnt == base && !busy, "R11 idle requests ignored", fr_cnt - base, 0);

        // directed corners
        run_op(3'd0, 10'h3FF, 0, 5, 1'b1);
        run_op(3'd2, 10'h000, 1, 3, 1'b1);
        run_op(3'd3, 10'h1A5, 2, 7, 1'b0);
        run_op(3'd1, 10'h2C3, 0, 0, 1'b0);
        run_op(3'd2, 10'h2AA, 2, 0, 1'b0);

        for (int i = 0; i < 14; i++) begin
            run_op(3'($urandom % 4), 10'($urandom), int'($urandom % 3),
                   int'($urandom % 40), 1'($urandom % 2));
        end
        finish_tb();
    end
endmodule